// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with condition flags

This block computes one 8-bit arithmetic or logic operation per cycle on an accumulator value and a second operand, and produces the new accumulator value together with an updated 8-bit flag byte. The incoming flag byte supplies the carry-in and the state that some operations keep or test. Each operation has its own rule for every flag bit: it may set the bit, clear it, keep it, or recompute it. The operations are add, add with carry, subtract, subtract with borrow, compare, negate, AND, OR, XOR, complement of the accumulator, set carry, complement carry and decimal adjust.

The datapath is combinational. A single register stage captures its output. The caller presents `acc`, `opnd`, `flags_in` and `op` with `in_valid` high. One clock edge later, `out_valid` is high and `result` and `flags_out` carry the answer. Decoding of instructions, register files, memory and 16-bit arithmetic all belong to the logic around this block.

Flag byte positions: sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1, carry at bit 0. Bits 5 and 3 carry no meaning here.

Top module: `alu8_flags`

## Requirements
- R1: Flag bits 5 and 3 of `flags_out` always equal bits 5 and 3 of `flags_in` from the same request, whatever the operation.
- R2: Add (op 0) gives acc+opnd, and add-with-carry (op 1) gives acc+opnd+flags_in[0]. Both set sign from bit 7 and zero when the result is 0. Both put the carry out of bit 7 in bit 0 and clear the subtract flag (bit 1).
- R3: Subtract (op 2) gives acc-opnd, subtract-with-borrow (op 3) gives acc-opnd-flags_in[0], and negate (op 5) gives 0-acc. Each sets sign and zero from the result and sets bit 1. Bit 0 is the borrow out of bit 7.
- R4: Compare (op 4) returns `result` equal to `acc`. Its flags are exactly those of subtract on the same operands.
- R5: For ops 0 to 5, bit 4 is the carry or borrow out of bit 3, and bit 2 is the signed two's-complement overflow of the 8-bit operation.
- R6: AND (op 6), OR (op 7) and XOR (op 8) set sign and zero from the result. They set bit 2 when the result has an even number of ones, and clear bits 1 and 0. Bit 4 is 1 for AND and 0 for OR and XOR.
- R7: Complement (op 9) returns ~acc and sets bits 4 and 1. Every other flag bit is kept.
- R8: Set-carry (op 10) returns acc, sets bit 0 and clears bits 4 and 1. Complement-carry (op 11) returns acc, inverts bit 0 and clears bit 1. Both keep all remaining flag bits.
- R9: Decimal adjust (op 12) forms a correction from the flags and the value of acc. The correction gets 0x06 when bit 4 is set or the low nibble exceeds 9. It gets 0x60, and the carry out is set, when bit 0 is set or acc exceeds 0x99; otherwise the carry is kept. The correction is subtracted when bit 1 is set and added when it is clear, and bit 1 is kept. Sign, zero and even parity are taken from the result. Bit 4 is (low nibble > 9) after an add, and (old bit 4 and low nibble < 6) after a subtract.
- R10: Op codes 13 to 15 return acc and leave the flag byte unchanged.
- R11: The outputs are registered with one cycle of latency. `out_valid` equals the previous cycle's `in_valid`. `result` and `flags_out` hold their values while `in_valid` is low. Synchronous reset clears `out_valid`, `result` and `flags_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for the operands on this cycle |
| op | input | 4 | Operation code (0 to 12 defined, 13 to 15 pass) |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte; bit 0 is the carry-in |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 8 | Registered new accumulator value |
| flags_out | output | 8 | Registered new flag byte |

## Verification
The only state is the output register, so any fault becomes visible at the ports on the cycle right after the request that triggers it. A wrong carry or half-carry path shows up as a bad bit 0 or bit 4 only for operand pairs that cross a nibble or byte boundary. For that reason the boundary pairs 0x7F+1, 0-1 and 0x80-1 are driven explicitly, along with decimal-adjust inputs on both the add path and the subtract path. A fault in the hold logic appears only in idle cycles. It is caught by comparing the outputs across a gap in the request strobe.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int OPW = 4;

  localparam int FB_S = 7;
  localparam int FB_Z = 6;
  localparam int FB_H = 4;
  localparam int FB_P = 2;
  localparam int FB_N = 1;
  localparam int FB_C = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_NEG = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_XOR = 4'd8,
    OP_CPL = 4'd9,
    OP_SCF = 4'd10,
    OP_CCF = 4'd11,
    OP_DAA = 4'd12,
    OP_R13 = 4'd13,
    OP_R14 = 4'd14,
    OP_R15 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  function automatic logic even_par(input logic [DW-1:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cy,
  output logic          hc,
  output logic          ov
);
  logic [DW:0] full;
  logic [NW:0] low;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
      low  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
      ov   = (a[DW-1] ^ b[DW-1]) & (full[DW-1] ^ a[DW-1]);
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
      low  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
      ov   = ~(a[DW-1] ^ b[DW-1]) & (full[DW-1] ^ a[DW-1]);
    end
    sum = full[DW-1:0];
    cy  = full[DW];
    hc  = low[NW];
  end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic_sel_e    sel,
  output logic [DW-1:0] res,
  output logic          hc
);
  always_comb begin
    unique case (sel)
      LG_AND:  begin res = a & b; hc = 1'b1; end
      LG_OR:   begin res = a | b; hc = 1'b0; end
      default: begin res = a ^ b; hc = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          nf,
  input  logic          hf,
  input  logic          cf,
  output logic [DW-1:0] res,
  output logic          cy,
  output logic          hc
);
  localparam logic [NW-1:0] NIB_MAX = NW'(9);
  localparam logic [DW-1:0] BYTE_MAX = DW'(8'h99);
  localparam logic [NW-1:0] NIB_SIX = NW'(6);

  logic          lo_fix;
  logic          hi_fix;
  logic [DW-1:0] corr;

  always_comb begin
    lo_fix = hf | (a[NW-1:0] > NIB_MAX);
    hi_fix = cf | (a > BYTE_MAX);
    corr   = {(hi_fix ? NW'(6) : NW'(0)), (lo_fix ? NW'(6) : NW'(0))};
    res    = nf ? (a - corr) : (a + corr);
    cy     = hi_fix;
    hc     = nf ? (hf & (a[NW-1:0] < NIB_SIX)) : (a[NW-1:0] > NIB_MAX);
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  opnd,
  input  logic [DW-1:0]  flags_in,
  output logic           out_valid,
  output logic [DW-1:0]  result,
  output logic [DW-1:0]  flags_out
);
  alu_op_e opc;
  assign opc = alu_op_e'(op);

  // arithmetic operand steering
  logic          is_sub;
  logic          use_cin;
  logic [DW-1:0] ar_a;
  logic [DW-1:0] ar_b;
  logic [DW-1:0] ar_sum;
  logic          ar_cy, ar_hc, ar_ov;

  always_comb begin
    is_sub  = (opc == OP_SUB) || (opc == OP_SBC) || (opc == OP_CMP) || (opc == OP_NEG);
    use_cin = (opc == OP_ADC) || (opc == OP_SBC);
    ar_a    = (opc == OP_NEG) ? '0 : acc;
    ar_b    = (opc == OP_NEG) ? acc : opnd;
  end

  alu8_addsub u_addsub (
    .a   (ar_a),
    .b   (ar_b),
    .cin (use_cin & flags_in[FB_C]),
    .sub (is_sub),
    .sum (ar_sum),
    .cy  (ar_cy),
    .hc  (ar_hc),
    .ov  (ar_ov)
  );

  logic_sel_e    lg_sel;
  logic [DW-1:0] lg_res;
  logic          lg_hc;

  always_comb begin
    case (opc)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_XOR;
    endcase
  end

  alu8_bitwise u_bitwise (
    .a   (acc),
    .b   (opnd),
    .sel (lg_sel),
    .res (lg_res),
    .hc  (lg_hc)
  );

  logic [DW-1:0] da_res;
  logic          da_cy, da_hc;

  alu8_decadj u_decadj (
    .a   (acc),
    .nf  (flags_in[FB_N]),
    .hf  (flags_in[FB_H]),
    .cf  (flags_in[FB_C]),
    .res (da_res),
    .cy  (da_cy),
    .hc  (da_hc)
  );

  // flag composition; bits not named below keep their incoming value
  logic [DW-1:0] nxt_res;
  logic [DW-1:0] nxt_flg;

  always_comb begin
    nxt_res = acc;
    nxt_flg = flags_in;
    case (opc)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP: begin
        if (opc != OP_CMP) nxt_res = ar_sum;
        nxt_flg[FB_S] = ar_sum[DW-1];
        nxt_flg[FB_Z] = (ar_sum == '0);
        nxt_flg[FB_H] = ar_hc;
        nxt_flg[FB_P] = ar_ov;
        nxt_flg[FB_N] = is_sub;
        nxt_flg[FB_C] = ar_cy;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nxt_res       = lg_res;
        nxt_flg[FB_S] = lg_res[DW-1];
        nxt_flg[FB_Z] = (lg_res == '0);
        nxt_flg[FB_H] = lg_hc;
        nxt_flg[FB_P] = even_par(lg_res);
        nxt_flg[FB_N] = 1'b0;
        nxt_flg[FB_C] = 1'b0;
      end
      OP_CPL: begin
        nxt_res       = ~acc;
        nxt_flg[FB_H] = 1'b1;
        nxt_flg[FB_N] = 1'b1;
      end
      OP_SCF: begin
        nxt_flg[FB_C] = 1'b1;
        nxt_flg[FB_H] = 1'b0;
        nxt_flg[FB_N] = 1'b0;
      end
      OP_CCF: begin
        nxt_flg[FB_C] = ~flags_in[FB_C];
        nxt_flg[FB_N] = 1'b0;
      end
      OP_DAA: begin
        nxt_res       = da_res;
        nxt_flg[FB_S] = da_res[DW-1];
        nxt_flg[FB_Z] = (da_res == '0);
        nxt_flg[FB_H] = da_hc;
        nxt_flg[FB_P] = even_par(da_res);
        nxt_flg[FB_C] = da_cy;
      end
      default: begin
        nxt_res = acc;
        nxt_flg = flags_in;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        flags_out <= nxt_flg;
      end
    end
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [OPW-1:0] op,
  input logic [DW-1:0]  acc,
  input logic [DW-1:0]  flags_in,
  input logic           out_valid,
  input logic [DW-1:0]  result,
  input logic [DW-1:0]  flags_out
);
  logic sub_grp, add_grp, lg_grp, pass_grp;
  assign sub_grp  = (op == 4'd2) || (op == 4'd3) || (op == 4'd4) || (op == 4'd5);
  assign add_grp  = (op == 4'd0) || (op == 4'd1);
  assign lg_grp   = (op == 4'd6) || (op == 4'd7) || (op == 4'd8);
  assign pass_grp = (op >= 4'd13);

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(flags_out)));

  p_spare_bits_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flags_out[5] == $past(flags_in[5]) && flags_out[3] == $past(flags_in[3])));

  p_cmp_keeps_acc_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd4) |=> (result == $past(acc)));

  p_sub_sets_n_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_grp) |=> flags_out[FB_N]);

  p_add_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && add_grp) |=> (!flags_out[FB_N] && (flags_out[FB_Z] == (result == '0))));

  p_logic_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lg_grp) |=> (!flags_out[FB_N] && !flags_out[FB_C] && flags_out[FB_P] == ~^result));

  p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pass_grp) |=> (result == $past(acc) && flags_out == $past(flags_in)));

  p_cpl_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd9) |=> (result == ~$past(acc) && flags_out[FB_H] && flags_out[FB_N]));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op        (op),
  .acc       (acc),
  .flags_in  (flags_in),
  .out_valid (out_valid),
  .result    (result),
  .flags_out (flags_out)
);

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc = '0;
  logic [7:0] opnd = '0;
  logic [7:0] flags_in = '0;
  logic       out_valid;
  logic [7:0] result;
  logic [7:0] flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_sent;

  always #4 clk = ~clk;

  alu8_flags u_alu8_flags (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .acc       (acc),
    .opnd      (opnd),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out)
  );

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic bit even8(int v);
    logic [7:0] t;
    t = v[7:0];
    return ($countones(t) % 2) == 0;
  endfunction

  function automatic int mk(int r, bit h, bit pv, bit n, bit cy, int f);
    return ((r >= 128) ? 128 : 0) | ((r == 0) ? 64 : 0) | (f & 40) |
           (h ? 16 : 0) | (pv ? 4 : 0) | (n ? 2 : 0) | (cy ? 1 : 0);
  endfunction

  function automatic logic [15:0] model(int o, int a, int b, int f);
    int r, nf, c, s, h, sr, x, y, cc, d, rr, lo, corr, co, n, hf;
    r = a; nf = f; c = f & 1;
    case (o)
      0, 1: begin
        cc = (o == 1) ? c : 0;
        s  = a + b + cc;
        h  = (a % 16) + (b % 16) + cc;
        sr = sx(a) + sx(b) + cc;
        r  = s % 256;
        nf = mk(r, h > 15, (sr < -128) || (sr > 127), 1'b0, s > 255, f);
      end
      2, 3, 4, 5: begin
        x  = (o == 5) ? 0 : a;
        y  = (o == 5) ? a : b;
        cc = (o == 3) ? c : 0;
        d  = x - y - cc;
        h  = (x % 16) - (y % 16) - cc;
        sr = sx(x) - sx(y) - cc;
        rr = (d + 256) % 256;
        nf = mk(rr, h < 0, (sr < -128) || (sr > 127), 1'b1, d < 0, f);
        r  = (o == 4) ? a : rr;
      end
      6, 7, 8: begin
        rr = (o == 6) ? (a & b) : (o == 7) ? (a | b) : (a ^ b);
        r  = rr;
        nf = mk(rr, o == 6, even8(rr), 1'b0, 1'b0, f);
      end
      9:  begin r = 255 - a; nf = f | 18; end
      10: begin nf = (f & ~18) | 1; end
      11: begin nf = (f & ~2) ^ 1; end
      12: begin
        n = (f >> 1) & 1; hf = (f >> 4) & 1; lo = a % 16;
        corr = 0; co = c;
        if (hf == 1 || lo > 9) corr = corr + 6;
        if (c == 1 || a > 153) begin corr = corr + 96; co = 1; end
        if (n == 1) begin
          rr = (a - corr + 256) % 256;
          h  = (hf == 1 && lo < 6) ? 1 : 0;
        end else begin
          rr = (a + corr) % 256;
          h  = (lo > 9) ? 1 : 0;
        end
        r  = rr;
        nf = mk(rr, h == 1, even8(rr), n == 1, co == 1, f);
      end
      default: begin r = a; nf = f; end
    endcase
    return {r[7:0], nf[7:0]};
  endfunction

  function automatic string tag_of(int o);
    if (o <= 1) return "R2";
    if (o == 4) return "R4";
    if (o <= 5) return "R3";
    if (o <= 8) return "R6";
    if (o == 9) return "R7";
    if (o <= 11) return "R8";
    if (o == 12) return "R9";
    return "R10";
  endfunction

  task automatic send(int o, int a, int b, int f, logic [15:0] e, string tg);
    @(negedge clk);
    op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; flags_in = f[7:0];
    in_valid = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tg);
    last_sent = e;
  endtask

  task automatic send_m(int o, int a, int b, int f);
    send(o, a, b, f, model(o, a, b, f), tag_of(o));
  endtask

  task automatic chk(bit ok, string tg, logic [15:0] act, logic [15:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tg, act, e);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11", {result, flags_out}, 16'hxxxx);
      end else begin
        logic [15:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk({result, flags_out} === e, tg, {result, flags_out}, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R11 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && result == 8'h00 && flags_out == 8'h00, "R11 reset",
        {7'b0, out_valid, result}, 16'h0000);
    rst = 1'b0;

    // directed corner vectors with hand-derived expectations
    send(0, 8'h7F, 8'h01, 8'h00, 16'h80_94, "R5 add overflow");
    send(1, 8'hFF, 8'h00, 8'h01, 16'h00_51, "R2 adc carry");
    send(2, 8'h00, 8'h01, 8'h00, 16'hFF_93, "R3 sub borrow");
    send(3, 8'h80, 8'h00, 8'h01, 16'h7F_16, "R5 sbc overflow");
    send(4, 8'h42, 8'h42, 8'h00, 16'h42_42, "R4 cmp equal");
    send(5, 8'h80, 8'h00, 8'h00, 16'h80_87, "R3 neg 0x80");
    send(6, 8'hF0, 8'h3C, 8'h00, 16'h30_14, "R6 and");
    send(8, 8'h55, 8'h55, 8'h00, 16'h00_44, "R6 xor zero");
    send(7, 8'h01, 8'h00, 8'hFF, 16'h01_28, "R1 or spare bits");
    send(9, 8'h5A, 8'h00, 8'hC1, 16'hA5_D3, "R7 cpl");
    send(10, 8'h33, 8'h00, 8'h12, 16'h33_01, "R8 scf");
    send(11, 8'h33, 8'h00, 8'h11, 16'h33_10, "R8 ccf");
    send(12, 8'h3C, 8'h00, 8'h00, 16'h42_14, "R9 daa add");
    send(12, 8'hEE, 8'h00, 8'h13, 16'h88_87, "R9 daa sub");
    send(12, 8'h9A, 8'h00, 8'h00, 16'h00_55, "R9 daa wrap");
    send(13, 8'h33, 8'h77, 8'hA5, 16'h33_A5, "R10 spare op");

    // R11 hold while idle
    @(negedge clk);
    in_valid = 1'b0;
    acc = 8'hFF; op = 4'd9;
    @(negedge clk);
    chk(out_valid == 1'b0 && {result, flags_out} == last_sent, "R11 hold",
        {result, flags_out}, last_sent);
    @(negedge clk);
    chk({result, flags_out} == last_sent, "R11 hold2", {result, flags_out}, last_sent);

    // R1 spare bits with random traffic over every op, back to back
    for (int k = 0; k < 40; k++) begin
      for (int o = 0; o < 16; o++) begin
        send_m(o, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
               int'($urandom_range(0, 255)));
      end
    end
    // R9 exhaustive-ish decimal adjust over a sweep with each flag mix
    for (int a = 0; a < 256; a += 7) begin
      for (int f = 0; f < 8; f++) begin
        send_m(12, a, 0, ((f & 1) != 0 ? 1 : 0) | ((f & 2) != 0 ? 2 : 0) | ((f & 4) != 0 ? 16 : 0));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 drain", 16'(exp_q.size()), 16'h0000);
    finish_run();
  end
endmodule